// File: doc/BRIEF.md
# Per-Node Request Acceptance Filter

This block sits beside the receive path of a serial-bus link and decides where each incoming asynchronous request should go. The decision depends only on the node that sent the request. The block keeps two enable bitmaps with one bit per node number. One bitmap steers requests into the physical request path. The other admits them into the ordinary asynchronous request receive context. Software writes each bitmap one 32-bit word at a time. Every word has a "set" address, which ORs ones into the word, and a "clear" address, which removes ones from it. A read from either address returns the word's current contents.

Request headers arrive on a valid/ready stream that carries the 16-bit source node ID. In that ID, bits 15..6 hold the bus number and bits 5..0 hold the node number. Each accepted header produces one routing result on a second valid/ready stream, one clock later.

Back-pressure works as follows. A header is taken on a clock edge where `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is high whenever the result register is empty or `route_ready` is high. Once `route_valid` rises, it stays high and `route_code` stays stable until a clock edge where `route_ready` is high. A producer must hold `hdr_valid` and `hdr_src_id` until its header is taken.

Top module: `req_node_filter`

## Requirements
- R1: After reset every bit of both bitmaps is 0 and every word reads as 0. `route_valid` is low, so every request is rejected until software enables nodes.
- R2: A write to a set address (cfg_addr[0]=0) ORs `cfg_wdata` into the selected word. Bits written as 0 keep their value.
- R3: A write to a clear address (cfg_addr[0]=1) clears every bit of the selected word that is 1 in `cfg_wdata`. Bits written as 0 keep their value.
- R4: The address bits select the target of a write or read. cfg_addr[2] picks the bitmap (0 asynchronous, 1 physical) and cfg_addr[1] picks the word (0 low, 1 high). `cfg_rdata` shows the selected word for both the set and the clear address.
- R5: Node number n uses bit n of the low word for n < 32 and bit n-32 of the high word for n ≥ 32. For example, node 50 is bit 18 of the high word.
- R6: For a local-bus request whose node has its physical bit set, the route code is 2'b10 (physical), whatever its asynchronous bit is.
- R7: For a local-bus request whose physical bit is clear, the route code is 2'b01 (asynchronous context) when the asynchronous bit is set. When both bits are clear, the code is 2'b00 (reject).
- R8: A request is local-bus only when its bus number is 10'h3FF or equals `own_bus`. Any other request is rejected with 2'b00 unless `any_bus_en` is high, in which case it is judged by the bitmaps.
- R9: The result of a header taken at one clock edge shows on `route_valid`/`route_code` after that edge. The code 2'b11 never appears.
- R10: While `route_valid` is high and `route_ready` is low, the result holds steady and `hdr_ready` is low.
- R11: When a register write and a taken header fall on the same edge, the header is judged against the bitmap contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: [2] bitmap, [1] word, [0] clear |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Contents of the selected word |
| own_bus | input | 10 | This node's own bus number |
| any_bus_en | input | 1 | Judge requests from any bus by the bitmaps |
| hdr_valid | input | 1 | Header available |
| hdr_ready | output | 1 | Header can be taken |
| hdr_src_id | input | 16 | Source node ID of the request |
| route_valid | output | 1 | Routing result available |
| route_ready | input | 1 | Consumer takes the result |
| route_code | output | 2 | 00 reject, 01 asynchronous context, 10 physical |

## Verification
The hardest case to reach is a header waiting behind a stalled result while software changes the very node bit that the header will be judged by. The header is taken only on the edge where `route_ready` returns, and that edge may also carry a write. The bench reaches this case with a directed step that writes and presents a header on the same edge. It then runs a long stretch with random `route_ready` stalls, frequent writes to the word holding the header's node, and headers drawn from local, own and foreign buses. A behavioural model checks every cycle.

// File: rtl/req_filter_pkg.sv
package req_filter_pkg;
  typedef enum logic [1:0] {
    ROUTE_REJECT = 2'b00,
    ROUTE_ASYNC  = 2'b01,
    ROUTE_PHYS   = 2'b10
  } route_e;
endpackage

// File: rtl/nodemask_bank.sv
module nodemask_bank #(
  parameter int NODE_W = 6,
  parameter int WORD_W = 32,
  localparam int NUM_NODES = 1 << NODE_W,
  localparam int NUM_WORDS = NUM_NODES / WORD_W,
  localparam int WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_clr,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NODE_W-1:0] node_sel,
  output logic              node_hit
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
  logic [NUM_NODES-1:0]             flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wr_word == WSEL_W'(w)) begin
          words_q[w] <= wr_clr ? (words_q[w] & ~wr_data) : (words_q[w] | wr_data);
        end
      end
    end
  end

  assign flat     = words_q;
  assign rd_data  = words_q[rd_word];
  assign node_hit = flat[node_sel];

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_clr) |=> ((words_q[$past(wr_word)] & $past(wr_data)) == $past(wr_data))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clr) |=> ((words_q[$past(wr_word)] & $past(wr_data)) == '0)); // R3
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words_q)); // R2
endmodule

// File: rtl/route_decide.sv
module route_decide
  import req_filter_pkg::*;
#(
  parameter int BUS_W = 10
) (
  input  logic [BUS_W-1:0] src_bus,
  input  logic [BUS_W-1:0] own_bus,
  input  logic             any_bus_en,
  input  logic             phys_hit,
  input  logic             async_hit,
  output route_e           route
);
  logic bus_ok;

  always_comb begin
    bus_ok = (src_bus == {BUS_W{1'b1}}) || (src_bus == own_bus) || any_bus_en;
    if (!bus_ok)        route = ROUTE_REJECT;
    else if (phys_hit)  route = ROUTE_PHYS;
    else if (async_hit) route = ROUTE_ASYNC;
    else                route = ROUTE_REJECT;
  end
endmodule

// File: rtl/route_stage.sv
module route_stage
  import req_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  route_e     in_route,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_code
);
  route_e code_q;
  logic   valid_q;

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_code  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= ROUTE_REJECT;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) code_q <= in_route;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code))); // R10
  AST_TAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code != 2'b11)); // R9
endmodule

// File: rtl/req_node_filter.sv
module req_node_filter
  import req_filter_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int BUS_W  = 10,
  parameter int WORD_W = 32,
  localparam int ID_W      = NODE_W + BUS_W,
  localparam int NUM_WORDS = (1 << NODE_W) / WORD_W,
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = WSEL_W + 2,
  localparam int BANK_POS  = WSEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [BUS_W-1:0]  own_bus,
  input  logic              any_bus_en,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [ID_W-1:0]   hdr_src_id,
  output logic              route_valid,
  input  logic              route_ready,
  output logic [1:0]        route_code
);
  logic [1:0]        bank_hit;
  logic [WORD_W-1:0] bank_rd [2];
  logic [BUS_W-1:0]  src_bus;
  logic [NODE_W-1:0] src_node;
  route_e            decided;

  assign src_bus  = hdr_src_id[ID_W-1:NODE_W];
  assign src_node = hdr_src_id[NODE_W-1:0];

  // bank 0: asynchronous context, bank 1: physical path
  for (genvar g = 0; g < 2; g++) begin : g_bank
    nodemask_bank #(.NODE_W(NODE_W), .WORD_W(WORD_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_addr[BANK_POS] == 1'(g))),
      .wr_clr   (cfg_addr[0]),
      .wr_word  (cfg_addr[WSEL_W:1]),
      .wr_data  (cfg_wdata),
      .rd_word  (cfg_addr[WSEL_W:1]),
      .rd_data  (bank_rd[g]),
      .node_sel (src_node),
      .node_hit (bank_hit[g])
    );
  end

  assign cfg_rdata = cfg_addr[BANK_POS] ? bank_rd[1] : bank_rd[0];

  route_decide #(.BUS_W(BUS_W)) u_decide (
    .src_bus    (src_bus),
    .own_bus    (own_bus),
    .any_bus_en (any_bus_en),
    .phys_hit   (bank_hit[1]),
    .async_hit  (bank_hit[0]),
    .route      (decided)
  );

  route_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (hdr_valid),
    .in_ready  (hdr_ready),
    .in_route  (decided),
    .out_valid (route_valid),
    .out_ready (route_ready),
    .out_code  (route_code)
  );

  AST_FOREIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !any_bus_en && (src_bus != {BUS_W{1'b1}}) && (src_bus != own_bus))
      |=> (route_code == 2'b00)); // R8
  AST_PHYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && bank_hit[1] && (src_bus == {BUS_W{1'b1}}))
      |=> (route_code == 2'b10)); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && !route_ready) |-> !hdr_ready); // R10
endmodule

// File: tb/sim_req_node_filter.sv
`timescale 1ns/100ps
module sim_req_node_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [9:0]  own_bus = 10'h155;
  logic        any_bus_en = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [15:0] hdr_src_id = '0;
  logic        route_valid;
  logic        route_ready = 1'b1;
  logic [1:0]  route_code;

  int vectors = 0;
  int miscompares = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [63:0] ra, rp;
  bit          m_ov;
  logic [1:0]  m_code;

  always #2 clk = ~clk;

  req_node_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .own_bus(own_bus),
    .any_bus_en(any_bus_en), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_src_id(hdr_src_id), .route_valid(route_valid),
    .route_ready(route_ready), .route_code(route_code)
  );

  function automatic logic [1:0] ref_route(input logic [15:0] id);
    logic [9:0] bus = id[15:6];
    int n = int'(id[5:0]);
    if (!(bus == 10'h3FF || bus == own_bus || any_bus_en)) return 2'b00; // R8
    if (rp[n]) return 2'b10;   // R6
    if (ra[n]) return 2'b01;   // R7
    return 2'b00;
  endfunction

  // model: decision from pre-write contents (R11), then register write
  always @(posedge clk) begin
    if (!rst_n) begin
      ra = '0; rp = '0; m_ov = 1'b0; m_code = 2'b00;
    end else begin
      automatic bit hr = !m_ov || route_ready;
      automatic logic [1:0] dec = ref_route(hdr_src_id);
      if (hr) begin
        m_ov = hdr_valid;
        if (hdr_valid) m_code = dec;
      end
      if (cfg_we) begin
        for (int b = 0; b < 32; b++) begin
          automatic int idx = (cfg_addr[1] ? 32 : 0) + b;
          if (cfg_wdata[b]) begin
            if (cfg_addr[2]) rp[idx] = !cfg_addr[0];
            else             ra[idx] = !cfg_addr[0];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      automatic logic [63:0] vec = cfg_addr[2] ? rp : ra;
      automatic logic [31:0] exp_rd = cfg_addr[1] ? vec[63:32] : vec[31:0];
      automatic bit exp_hr = !m_ov || route_ready;
      vectors++;
      if (route_valid !== m_ov) begin
        miscompares++;
        $display("FAIL %s R9 route_valid actual=%0b expected=%0b", cur_req, route_valid, m_ov);
      end
      if (m_ov && route_code !== m_code) begin
        miscompares++;
        $display("FAIL %s R6/R7/R8 route_code actual=%0b expected=%0b", cur_req, route_code, m_code);
      end
      if (hdr_ready !== exp_hr) begin
        miscompares++;
        $display("FAIL %s R10 hdr_ready actual=%0b expected=%0b", cur_req, hdr_ready, exp_hr);
      end
      if (cfg_rdata !== exp_rd) begin
        miscompares++;
        $display("FAIL %s R4 cfg_rdata addr=%0d actual=%h expected=%h", cur_req, cfg_addr, cfg_rdata, exp_rd);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  task automatic wr(input bit phys, input bit hi, input bit clr, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = {phys, hi, clr}; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [9:0] bus, input logic [5:0] node);
    hdr_valid = 1'b1; hdr_src_id = {bus, node};
    tick();
    hdr_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    checking = 1'b1;
    // R1: reset contents are zero at every address, requests rejected
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin cfg_addr = 3'(a); tick(); end
    send(10'h3FF, 6'd5); tick();
    // R2 R5: set async node 50 (high bit 18), phys node 51 (high bit 19), node 3 low
    cur_req = "R2";
    wr(1'b0, 1'b1, 1'b0, 32'h1 << 18);
    wr(1'b1, 1'b1, 1'b0, 32'h1 << 19);
    wr(1'b0, 1'b0, 1'b0, 32'h8);
    wr(1'b1, 1'b0, 1'b0, 32'h8);
    wr(1'b0, 1'b1, 1'b0, 32'h1 << 2);   // node 34 added, node 50 kept
    cur_req = "R4";
    for (int a = 0; a < 8; a++) begin cfg_addr = 3'(a); tick(); end
    // R5 R6 R7: routing per node
    cur_req = "R5";
    send(10'h3FF, 6'd50); send(10'h3FF, 6'd51); send(10'h3FF, 6'd34);
    cur_req = "R6";
    send(10'h3FF, 6'd3);
    cur_req = "R7";
    send(10'h3FF, 6'd4); send(10'h3FF, 6'd18);
    // R8: own bus accepted, foreign rejected, any-bus enable opens it
    cur_req = "R8";
    send(10'h155, 6'd50); send(10'h002, 6'd50); send(10'h002, 6'd51);
    any_bus_en = 1'b1;
    send(10'h002, 6'd50); send(10'h002, 6'd51);
    any_bus_en = 1'b0;
    // R3: clear phys node 3 only, async bit stays -> node 3 now asynchronous
    cur_req = "R3";
    wr(1'b1, 1'b0, 1'b1, 32'h8);
    cfg_addr = 3'b100; tick();
    send(10'h3FF, 6'd3);
    wr(1'b0, 1'b1, 1'b1, 32'h1 << 18);
    cfg_addr = 3'b010; tick();
    send(10'h3FF, 6'd50);
    // R11: write and header on the same edge
    cur_req = "R11";
    wr(1'b0, 1'b0, 1'b0, 32'h80);
    cfg_we = 1'b1; cfg_addr = 3'b001; cfg_wdata = 32'h80;
    hdr_valid = 1'b1; hdr_src_id = {10'h3FF, 6'd7};
    tick();
    cfg_we = 1'b0; hdr_valid = 1'b0;
    send(10'h3FF, 6'd7);
    // R10: stall output with a waiting header
    cur_req = "R10";
    route_ready = 1'b0;
    send(10'h3FF, 6'd34);
    hdr_valid = 1'b1; hdr_src_id = {10'h3FF, 6'd51};
    repeat (3) tick();
    route_ready = 1'b1;
    tick();
    hdr_valid = 1'b0;
    tick();
    // random mix: stalls, writes near the header's node, mixed buses
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      automatic bit took;
      route_ready = ($urandom % 3) != 0;
      cfg_we = ($urandom % 3) == 0;
      cfg_addr = 3'($urandom);
      cfg_wdata = (($urandom % 2) != 0) ? $urandom : (32'h1 << ($urandom % 32));
      if (($urandom % 50) == 0) any_bus_en = ~any_bus_en;
      if (!hdr_valid && (($urandom % 4) != 0)) begin
        automatic int pick = $urandom % 3;
        hdr_valid = 1'b1;
        hdr_src_id[5:0] = 6'($urandom);
        hdr_src_id[15:6] = (pick == 0) ? 10'h3FF : (pick == 1) ? own_bus : 10'($urandom);
      end
      #0.5;
      took = hdr_valid && hdr_ready;
      @(negedge clk); #0.5;
      if (took) hdr_valid = 1'b0;
    end
    cfg_we = 1'b0; hdr_valid = 1'b0; route_ready = 1'b1;
    repeat (3) tick();
    finish_run();
  end
endmodule